// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block produces, once per reference-rate update, the integer ratio that a dual-modulus feedback counter should use for its next cycle. The average of these ratios equals INT + FRAC/MOD. The per-update ratio is dithered around INT by three cascaded first-order accumulators. Each accumulator wraps at a modulus that software programs at run time. The fractional error is therefore pushed to high offset frequencies with third-order shaping.

On every update, a caller presents an integer part, a fractional numerator, a modulus and a prescaler choice, together with a one-cycle update enable. Settings that are in range are taken at once. Settings that are out of range raise an error flag, and the block keeps using the last settings that were in range. When FRAC is zero, the block acts as a plain integer divider.

Top module: `frac_div_seq`

## Requirements
- R1: While reset is asserted, and until the first update, `nOut` is 0 and `rangeErr` is 0.
- R2: `nOut` and `rangeErr` change only on the clock edge at which `tickEn` is sampled high, and they hold their values on every other edge.
- R3: Each update advances three accumulators that wrap modulo MOD. A stage sets its carry when its sum is at least MOD, and then subtracts MOD. Stage 1 adds FRAC. Stages 2 and 3 add the new residue of the stage before them. The output is N = INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' marks the value from the previous update.
- R4: Every output lies between INT − 3 and INT + 4, where INT is the setting in force for that update.
- R5: While the FRAC in force is 0, every update outputs exactly INT.
- R6: Over the first MOD updates after a restart, with constant settings, the outputs sum to between MOD·INT + FRAC − 1 and MOD·INT + FRAC + 2.
- R7: An in-range update whose FRAC or MOD differs from the settings in force clears all accumulator residues and all stored carries before it steps. Its own output is therefore exactly INT.
- R8: INT is in range from 23 to 32767 when `preSel` is 0 (4/5 prescaler). It is in range from 75 to 65535 when `preSel` is 1 (8/9 prescaler).
- R9: MOD is in range from 2 to 4095, and FRAC is in range only when it is below MOD.
- R10: An update with any value out of range sets `rangeErr` to 1 and leaves the settings unchanged. That update and later ones continue the sequence of the last in-range settings. The next in-range update clears `rangeErr` to 0.
- R11: Until the first in-range update, the settings in force are INT = 23, FRAC = 0, MOD = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle update enable at the reference rate |
| intIn | input | 16 | Integer part of the ratio |
| fracIn | input | 12 | Fractional numerator |
| modIn | input | 12 | Fractional modulus |
| preSel | input | 1 | Prescaler choice: 0 = 4/5, 1 = 8/9 |
| nOut | output | 17 | Divide value for the next feedback cycle |
| rangeErr | output | 1 | Last update carried settings out of range |

## Verification
Assertions check the following on every cycle:
- the output stays within its INT − 3 to INT + 4 window;
- an update with FRAC at zero yields exactly INT;
- the output holds between updates;
- residues stay below the modulus;
- the stored settings are always in range;
- out-of-range updates leave the stored settings unchanged.

Only the bench's scenarios can show:
- the exact dither sequence;
- the bounded sum over one modulus period;
- the clearing of history on a change of FRAC or MOD;
- the exact INT limits at each prescaler edge;
- the continuation of the old sequence across rejected updates.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int INT_W  = 16;
  localparam int MOD_W  = 12;
  localparam int NOUT_W = INT_W + 1;
  localparam int NSTG   = 3;

  typedef struct packed {
    logic [INT_W-1:0] intV;
    logic [MOD_W-1:0] fracV;
    logic [MOD_W-1:0] modV;
  } cfg_t;

  typedef struct packed {
    logic step;
    logic restart;
  } strobe_t;
endpackage

// File: rtl/frac_div_acc.sv
module frac_div_acc #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  input  logic         restart,
  input  logic [W-1:0] modV,
  input  logic [W-1:0] addIn,
  output logic [W-1:0] resNext,
  output logic         carry
);
  logic [W-1:0] res;
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W:0]   diff;

  always_comb begin
    base    = restart ? '0 : res;
    sum     = {1'b0, base} + {1'b0, addIn};
    diff    = sum - {1'b0, modV};
    carry   = (sum >= {1'b0, modV});
    resNext = carry ? diff[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) res <= '0;
    else if (step) res <= resNext;
  end

  // R3: residue after a step is below the modulus used for that step
  p_res_below_mod_r3: assert property (@(posedge clk) disable iff (!rstN)
    step |=> (res < $past(modV)));
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl import frac_div_pkg::*; #(
  parameter int INT_MIN_LO = 23,
  parameter int INT_MIN_HI = 75,
  parameter int MOD_MIN    = 2,
  parameter int RST_INT    = 23,
  parameter int RST_FRAC   = 0,
  parameter int RST_MOD    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [INT_W-1:0] intIn,
  input  logic [MOD_W-1:0] fracIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic             preSel,
  output cfg_t             effCfg,
  output strobe_t          strb,
  output logic             rangeErr
);
  localparam int INT_MAX_LO = 2 ** (INT_W - 1) - 1;

  cfg_t cfgQ;
  logic intOk, modOk, fracOk, inLegal;

  always_comb begin
    if (preSel) intOk = (intIn >= INT_W'(INT_MIN_HI));
    else        intOk = (intIn >= INT_W'(INT_MIN_LO)) && (intIn <= INT_W'(INT_MAX_LO));
    modOk   = (modIn >= MOD_W'(MOD_MIN));
    fracOk  = (fracIn < modIn);
    inLegal = intOk && modOk && fracOk;
  end

  always_comb begin
    if (tickEn && inLegal) effCfg = '{intV: intIn, fracV: fracIn, modV: modIn};
    else                   effCfg = cfgQ;
    strb.step    = tickEn;
    strb.restart = tickEn && inLegal &&
                   ((fracIn != cfgQ.fracV) || (modIn != cfgQ.modV));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= '{intV: INT_W'(RST_INT), fracV: MOD_W'(RST_FRAC), modV: MOD_W'(RST_MOD)};
      rangeErr <= 1'b0;
    end else if (tickEn) begin
      if (inLegal) cfgQ <= effCfg;
      rangeErr <= !inLegal;
    end
  end

  // R8: INT above the 4/5 ceiling is flagged
  p_int_ceiling_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !preSel && (intIn > INT_W'(INT_MAX_LO))) |=> rangeErr);

  // R10: a rejected FRAC leaves the settings unchanged
  p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && (fracIn >= modIn)) |=> $stable(cfgQ));

  // R9: settings in force are always within range
  p_cfg_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.fracV < cfgQ.modV) && (cfgQ.modV >= MOD_W'(MOD_MIN)));
endmodule

// File: rtl/frac_div_dp.sv
module frac_div_dp import frac_div_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           strb,
  output logic [NOUT_W-1:0] nOut
);
  logic [MOD_W-1:0] stgIn  [NSTG];
  logic [MOD_W-1:0] stgRes [NSTG];
  logic [NSTG-1:0]  carry;

  for (genvar g = 0; g < NSTG; g++) begin : gStage
    if (g == 0) begin : gFirst
      assign stgIn[g] = cfg.fracV;
    end else begin : gNext
      assign stgIn[g] = stgRes[g-1];
    end
    frac_div_acc #(.W(MOD_W)) i_acc (
      .clk     (clk),
      .rstN    (rstN),
      .step    (strb.step),
      .restart (strb.restart),
      .modV    (cfg.modV),
      .addIn   (stgIn[g]),
      .resNext (stgRes[g]),
      .carry   (carry[g])
    );
  end

  logic c2d, c3d, c3dd;
  logic c2dB, c3dB, c3ddB;
  logic [3:0] corr;
  logic [NOUT_W-1:0] nNext;

  always_comb begin
    c2dB  = strb.restart ? 1'b0 : c2d;
    c3dB  = strb.restart ? 1'b0 : c3d;
    c3ddB = strb.restart ? 1'b0 : c3dd;
    corr  = {3'b0, carry[0]}
          + {3'b0, carry[1]} - {3'b0, c2dB}
          + {3'b0, carry[2]} - {2'b0, c3dB, 1'b0} + {3'b0, c3ddB};
    nNext = {1'b0, cfg.intV} + {{(NOUT_W-4){corr[3]}}, corr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nOut <= '0;
      c2d  <= 1'b0;
      c3d  <= 1'b0;
      c3dd <= 1'b0;
    end else if (strb.step) begin
      nOut <= nNext;
      c2d  <= carry[1];
      c3dd <= c3dB;
      c3d  <= carry[2];
    end
  end

  // R4: output within INT-3 .. INT+4
  p_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((int'(nOut) + 3 >= int'($past(cfg.intV))) &&
                   (int'(nOut) <= int'($past(cfg.intV)) + 4)));

  // R5: zero fraction gives the bare integer
  p_int_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && (cfg.fracV == '0)) |=> (nOut == NOUT_W'($past(cfg.intV))));

  // R2: output holds between updates
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(nOut));
endmodule

// File: rtl/frac_div_seq.sv
module frac_div_seq import frac_div_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [INT_W-1:0]  intIn,
  input  logic [MOD_W-1:0]  fracIn,
  input  logic [MOD_W-1:0]  modIn,
  input  logic              preSel,
  output logic [NOUT_W-1:0] nOut,
  output logic              rangeErr
);
  cfg_t    effCfg;
  strobe_t strb;

  frac_div_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .intIn    (intIn),
    .fracIn   (fracIn),
    .modIn    (modIn),
    .preSel   (preSel),
    .effCfg   (effCfg),
    .strb     (strb),
    .rangeErr (rangeErr)
  );

  frac_div_dp i_dp (
    .clk  (clk),
    .rstN (rstN),
    .cfg  (effCfg),
    .strb (strb),
    .nOut (nOut)
  );
endmodule

// File: tb/test_frac_div_seq.sv
module test_frac_div_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic [15:0] i;
    logic [11:0] f;
    logic [11:0] m;
    logic        p;
    logic        e;
  } vec_t;

  // stimulus and expected error flag; expected N comes from the model
  localparam vec_t VECS [NVEC] = '{
    '{i:16'd22,    f:12'd0,    m:12'd2,    p:1'b0, e:1'b1},
    '{i:16'd23,    f:12'd0,    m:12'd2,    p:1'b0, e:1'b0},
    '{i:16'd32767, f:12'd1,    m:12'd2,    p:1'b0, e:1'b0},
    '{i:16'd32768, f:12'd1,    m:12'd2,    p:1'b0, e:1'b1},
    '{i:16'd32768, f:12'd1,    m:12'd2,    p:1'b1, e:1'b0},
    '{i:16'd74,    f:12'd1,    m:12'd3,    p:1'b1, e:1'b1},
    '{i:16'd75,    f:12'd1,    m:12'd3,    p:1'b1, e:1'b0},
    '{i:16'd65535, f:12'd2,    m:12'd3,    p:1'b1, e:1'b0},
    '{i:16'd100,   f:12'd0,    m:12'd1,    p:1'b0, e:1'b1},
    '{i:16'd100,   f:12'd5,    m:12'd5,    p:1'b0, e:1'b1},
    '{i:16'd100,   f:12'd4094, m:12'd4095, p:1'b0, e:1'b0},
    '{i:16'd100,   f:12'd4094, m:12'd4095, p:1'b0, e:1'b0},
    '{i:16'd100,   f:12'd4095, m:12'd4095, p:1'b0, e:1'b1},
    '{i:16'd1000,  f:12'd7,    m:12'd13,   p:1'b1, e:1'b0},
    '{i:16'd1000,  f:12'd7,    m:12'd13,   p:1'b1, e:1'b0},
    '{i:16'd1000,  f:12'd7,    m:12'd13,   p:1'b1, e:1'b0},
    '{i:16'd1000,  f:12'd7,    m:12'd13,   p:1'b1, e:1'b0},
    '{i:16'd1000,  f:12'd7,    m:12'd13,   p:1'b1, e:1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic [15:0] intIn;
  logic [11:0] fracIn;
  logic [11:0] modIn;
  logic        preSel;
  logic [16:0] nOut;
  logic        rangeErr;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of the requirements
  int mInt, mFrac, mMod;
  int a1, a2, a3, c2d, c3d, c3dd;
  int expN, expErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_div_seq i_frac_div_seq (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .intIn(intIn), .fracIn(fracIn),
    .modIn(modIn), .preSel(preSel), .nOut(nOut), .rangeErr(rangeErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mInt = 23; mFrac = 0; mMod = 2;            // R11 defaults
    a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
  endtask

  task automatic modelStep(input int i, input int f, input int m, input int p);
    bit legal;
    int s1, s2, s3, k1, k2, k3;
    legal = (p != 0 ? (i >= 75) : (i >= 23 && i <= 32767)) && (m >= 2) && (f < m);
    if (legal) begin
      if (f != mFrac || m != mMod) begin       // R7 restart
        a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
      end
      mInt = i; mFrac = f; mMod = m;
    end
    expErr = legal ? 0 : 1;
    s1 = a1 + mFrac; k1 = (s1 >= mMod) ? 1 : 0; a1 = s1 - k1 * mMod;
    s2 = a2 + a1;    k2 = (s2 >= mMod) ? 1 : 0; a2 = s2 - k2 * mMod;
    s3 = a3 + a2;    k3 = (s3 >= mMod) ? 1 : 0; a3 = s3 - k3 * mMod;
    expN = mInt + k1 + (k2 - c2d) + (k3 - 2 * c3d + c3dd);
    c2d = k2; c3dd = c3d; c3d = k3;
  endtask

  task automatic applyTick(input int i, input int f, input int m, input int p, input string req);
    modelStep(i, f, m, p);
    @(negedge clk);
    intIn = 16'(i); fracIn = 12'(f); modIn = 12'(m); preSel = p[0]; tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    check(int'(nOut) == expN, {req, " R3 ratio"}, int'(nOut), expN);
    check(int'(rangeErr) == expErr, {req, " R10 flag"}, int'(rangeErr), expErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int sum, lo, hi;
    logic [16:0] held;
    rstN = 1'b0; tickEn = 1'b0; intIn = '0; fracIn = '0; modIn = '0; preSel = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    check(nOut == 17'd0, "R1 reset nOut", int'(nOut), 0);
    check(rangeErr == 1'b0, "R1 reset rangeErr", int'(rangeErr), 0);
    rstN = 1'b1;

    // vector table: limits R8, R9, error handling R10, defaults R11
    for (int v = 0; v < NVEC; v++) begin
      applyTick(int'(VECS[v].i), int'(VECS[v].f), int'(VECS[v].m), int'(VECS[v].p), "R8/R9 table");
      check(int'(rangeErr) == int'(VECS[v].e), "R8 R9 table flag", int'(rangeErr), int'(VECS[v].e));
    end

    // R2: output holds without updates
    held = nOut;
    repeat (6) @(negedge clk);
    check(nOut == held, "R2 hold", int'(nOut), int'(held));

    // R5: integer-only operation
    for (int k = 0; k < 30; k++) begin
      applyTick(500, 0, 97, 0, "R5");
      check(nOut == 17'd500, "R5 integer only", int'(nOut), 500);
    end

    // R6 small modulus period sum; R7 restart output equals INT
    sum = 0;
    for (int k = 0; k < 7; k++) begin
      applyTick(200, 3, 7, 0, "R6");
      if (k == 0) check(nOut == 17'd200, "R7 restart", int'(nOut), 200);
      sum += int'(nOut);
    end
    lo = 7 * 200 + 3 - 1; hi = 7 * 200 + 3 + 2;
    check(sum >= lo && sum <= hi, "R6 sum small", sum, 7 * 200 + 3);

    // R6 and R4 over a full large-modulus period
    sum = 0;
    for (int k = 0; k < 4095; k++) begin
      applyTick(40000, 1234, 4095, 1, "R4");
      check(int'(nOut) >= 39997 && int'(nOut) <= 40004, "R4 window", int'(nOut), 40000);
      sum += int'(nOut);
    end
    lo = 4095 * 40000 + 1234 - 1; hi = 4095 * 40000 + 1234 + 2;
    check(sum >= lo && sum <= hi, "R6 sum large", sum, 4095 * 40000 + 1234);

    // R7: FRAC change with same MOD restarts history
    applyTick(40000, 2000, 4095, 1, "R7");
    check(nOut == 17'd40000, "R7 restart frac", int'(nOut), 40000);

    // R10: rejected update keeps sequence, next legal clears flag
    applyTick(40000, 4095, 4095, 1, "R10 reject");
    check(rangeErr == 1'b1, "R10 set", int'(rangeErr), 1);
    applyTick(40000, 2000, 4095, 1, "R10 resume");
    check(rangeErr == 1'b0, "R10 clear", int'(rangeErr), 0);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(nOut == 17'd0, "R1 re-reset nOut", int'(nOut), 0);
    check(rangeErr == 1'b0, "R1 re-reset rangeErr", int'(rangeErr), 0);
    rstN = 1'b1; modelReset();
    applyTick(10, 0, 2, 0, "R11 after reset");
    check(nOut == 17'd23, "R11 default", int'(nOut), 23);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule